// File: doc/BRIEF.md
# Ping-pong DMA channel

A single DMA channel that moves data between one peripheral and memory in either direction, using two buffer descriptors that the hardware alternates between. Each descriptor is a 4-byte aligned start address and a 13-bit byte count. Software arms one descriptor by setting its start bit while the channel drains the other. When the active descriptor's count reaches zero, the channel marks it done and turns to the other descriptor. If that descriptor is already armed, the stream carries on with no software involvement.

Control is through an eight-word register window. The control/status word has three views: a write-1-to-set address, a write-1-to-clear address and a read-back address. Each transfer beat takes two steps. The channel first fetches a datum from the source port and then delivers it to the destination port, each step through a request/acknowledge handshake. The peripheral raises a burst request to ask for a burst of 4 or 8 beats.

Top module: `pingpong_dma`

## Requirements
- R1: After reset, the control word, the configuration word, both addresses and both counts read 0, and `irq` is low.
- R2: A register write uses word offset `reg_addr[4:2]`. The eight offsets, in order, are: configuration, set, clear, control read-back, address A, count A, address B, count B. A 1 written at the set offset (0x04) sets the matching control bit. A 1 written at the clear offset (0x08) clears it. Bits written as 0 leave the control word unchanged. The control word reads back at offset 0x0C.
- R3: The control bits are: bit0 run, bit1 interrupt enable, bit2 error, bit3 done A, bit4 start A, bit5 done B, bit6 start B, bit7 active buffer (1 = B). A write at the set offset cannot set bit2, bit3, bit5 or bit7. Neither the set offset nor the clear offset can change bit7.
- R4: A write to an address register drops bits 1:0, so the address reads back 4-byte aligned. A count register keeps only bits 12:0, so the largest count is 0x1FFF. The configuration word keeps bits 7:0: bit0 direction (1 = peripheral to memory), bit1 byte swap, bit2 burst of 8 (0 = burst of 4), bit3 16-bit width, bits 7:4 device select, which drives `dev_sel`.
- R5: `irq` is high exactly when interrupt enable is set and at least one of error, done A or done B is set.
- R6: In the peripheral-to-memory direction, each beat reads the peripheral and then writes memory at the active buffer's current address. After every beat, that buffer's address register advances and its count falls by the step: 2 bytes at 16-bit width, otherwise 1 byte.
- R7: When run and the active buffer's start bit are both set and its count is 0, the channel clears that start bit, sets that buffer's done bit and toggles bit7. If the other buffer's start bit is set, transfer continues there.
- R8: A burst starts only when `dev_dreq` is high while the channel is idle. A burst moves 4 beats (8 with the burst bit set), or fewer if the count runs out first.
- R9: In the memory-to-peripheral direction, each beat reads memory at the current address and writes the peripheral. At 8-bit width, only the low byte passes, and the upper byte sent is 0.
- R10: At 16-bit width with the swap bit set, the two bytes of every datum are exchanged on the way through.
- R11: Clearing run stops the channel after the beat in flight, and the address and count are preserved. Setting run again resumes from that point.
- R12: An error response on the memory port sets error and clears run. The failing beat leaves the address and count unchanged.
- R13: With run set and neither start bit set, the channel issues no request on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| irq | output | 1 | Interrupt |
| dev_sel | output | 4 | Peripheral select from configuration |
| dev_dreq | input | 1 | Peripheral asks for a burst |
| dev_req | output | 1 | Peripheral beat request |
| dev_we | output | 1 | 1 = write to peripheral |
| dev_wdata | output | DW | Data to peripheral |
| dev_rdata | input | DW | Data from peripheral |
| dev_ack | input | 1 | Peripheral beat acknowledge |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ack | input | 1 | Memory beat acknowledge |
| mem_err | input | 1 | Error response, valid with `mem_ack` |

## Verification
The properties assume that each acknowledge is a single-cycle pulse given only while the matching request is high. They also assume that software does not rewrite the configuration word or the active buffer's address while a beat is in flight. The bench's memory and peripheral models answer one cycle after a request and drop the acknowledge on the following cycle. The bench changes configuration and descriptors only while the channel is quiescent: run is clear, or the armed buffers are done. The one exception is a write to the clear offset during the pause test, which does not touch the address or count registers.

// File: rtl/pingpong_dma.sv
module pingpong_dma #(
  parameter int AW = 32,
  parameter int CW = 13,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          irq,
  output logic [3:0]    dev_sel,
  input  logic          dev_dreq,
  output logic          dev_req,
  output logic          dev_we,
  output logic [DW-1:0] dev_wdata,
  input  logic [DW-1:0] dev_rdata,
  input  logic          dev_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err
);
  localparam int HW = DW / 2;
  localparam int B_RUN = 0, B_IE = 1, B_ERR = 2, B_DNA = 3, B_STA = 4, B_DNB = 5, B_STB = 6, B_ACT = 7;
  localparam logic [7:0] SET_MASK = 8'h53;
  localparam logic [7:0] CLR_MASK = 8'h7F;

  typedef enum logic [1:0] {ST_IDLE, ST_SRC, ST_DST} st_t;

  st_t           st_q;
  logic [7:0]    cfg_q, ctl_q, ctl_n;
  logic [AW-1:0] adr_q [2];
  logic [CW-1:0] cnt_q [2];
  logic [3:0]    beats_q;
  logic [DW-1:0] dat_q, xf;

  wire [2:0] wsel = reg_addr[4:2];
  wire unused_lsb = &{1'b0, reg_addr[1:0]};

  wire dir_in = cfg_q[0];
  wire swap   = cfg_q[1];
  wire burst8 = cfg_q[2];
  wire wide   = cfg_q[3];
  wire act    = ctl_q[B_ACT];
  wire run    = ctl_q[B_RUN];
  wire armed  = act ? ctl_q[B_STB] : ctl_q[B_STA];

  wire [CW-1:0] cnt_act = cnt_q[act];
  wire [CW-1:0] step    = (wide && cnt_act != CW'(1)) ? CW'(2) : CW'(1);

  assign mem_req = (st_q == ST_SRC && !dir_in) || (st_q == ST_DST && dir_in);
  assign dev_req = (st_q == ST_SRC && dir_in) || (st_q == ST_DST && !dir_in);
  assign mem_we  = (st_q == ST_DST);
  assign dev_we  = (st_q == ST_DST);
  assign mem_addr = adr_q[act];

  always_comb begin
    if (!wide)     xf = {{(DW-8){1'b0}}, dat_q[7:0]};
    else if (swap) xf = {dat_q[HW-1:0], dat_q[DW-1:HW]};
    else           xf = dat_q;
  end
  assign mem_wdata = xf;
  assign dev_wdata = xf;

  wire ack_now   = (mem_req && mem_ack) || (dev_req && dev_ack);
  wire fault     = mem_req && mem_ack && mem_err;
  wire beat_done = (st_q == ST_DST) && ack_now && !fault;
  wire cmpl      = (st_q == ST_IDLE) && run && armed && (cnt_act == '0);
  wire go        = (st_q == ST_IDLE) && run && armed && (cnt_act != '0) && dev_dreq;

  assign irq     = ctl_q[B_IE] & (ctl_q[B_ERR] | ctl_q[B_DNA] | ctl_q[B_DNB]);
  assign dev_sel = cfg_q[7:4];

  always_comb begin
    ctl_n = ctl_q;
    if (reg_we && wsel == 3'd1) ctl_n = ctl_n | (reg_wdata[7:0] & SET_MASK);
    if (reg_we && wsel == 3'd2) ctl_n = ctl_n & ~(reg_wdata[7:0] & CLR_MASK);
    if (fault) begin
      ctl_n[B_ERR] = 1'b1;
      ctl_n[B_RUN] = 1'b0;
    end
    if (cmpl) begin
      if (act) begin
        ctl_n[B_STB] = 1'b0;
        ctl_n[B_DNB] = 1'b1;
      end else begin
        ctl_n[B_STA] = 1'b0;
        ctl_n[B_DNA] = 1'b1;
      end
      ctl_n[B_ACT] = ~act;
    end
  end

  always_comb begin
    case (wsel)
      3'd0:    reg_rdata = {{(AW-8){1'b0}}, cfg_q};
      3'd3:    reg_rdata = {{(AW-8){1'b0}}, ctl_q};
      3'd4:    reg_rdata = adr_q[0];
      3'd5:    reg_rdata = {{(AW-CW){1'b0}}, cnt_q[0]};
      3'd6:    reg_rdata = adr_q[1];
      3'd7:    reg_rdata = {{(AW-CW){1'b0}}, cnt_q[1]};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ctl_q <= '0;
      for (int i = 0; i < 2; i++) begin
        adr_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      ctl_q <= ctl_n;
      if (reg_we && wsel == 3'd0) cfg_q <= reg_wdata[7:0];
      for (int i = 0; i < 2; i++) begin
        if (reg_we && wsel == 3'(4 + 2 * i)) adr_q[i] <= {reg_wdata[AW-1:2], 2'b00};
        if (reg_we && wsel == 3'(5 + 2 * i)) cnt_q[i] <= reg_wdata[CW-1:0];
      end
      if (beat_done) begin
        adr_q[act] <= adr_q[act] + {{(AW-CW){1'b0}}, step};
        cnt_q[act] <= cnt_act - step;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      beats_q <= '0;
      dat_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (go) begin
          st_q    <= ST_SRC;
          beats_q <= burst8 ? 4'd8 : 4'd4;
        end
        ST_SRC: begin
          if (fault) st_q <= ST_IDLE;
          else if (ack_now) begin
            dat_q <= dir_in ? dev_rdata : mem_rdata;
            st_q  <= ST_DST;
          end
        end
        ST_DST: begin
          if (fault) st_q <= ST_IDLE;
          else if (ack_now) begin
            if (!run || cnt_act == step || beats_q == 4'd1) st_q <= ST_IDLE;
            else begin
              st_q    <= ST_SRC;
              beats_q <= beats_q - 4'd1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pingpong_dma_chk.sv
module pingpong_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    ctl,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          dev_req
);
  assert_ports_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, dev_req}));

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_done_a_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[3]) |-> $fell(ctl[4]));

  assert_done_b_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[5]) |-> $fell(ctl[6]));

  assert_active_swap_on_completion_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl[7]) |-> ($fell(ctl[4]) || $fell(ctl[6])));

  assert_error_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[2]) |-> !ctl[0]);

  assert_quiet_without_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[0] && !mem_req && !dev_req) |=> (!mem_req && !dev_req));
endmodule

bind pingpong_dma pingpong_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl(ctl_q), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .dev_req(dev_req)
);

// File: tb/sim_pingpong_dma.sv
`timescale 1ns/1ps
module sim_pingpong_dma;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, dev_dreq = 0, dev_req, dev_we, dev_ack, mem_req, mem_we, mem_ack, mem_err;
  logic [3:0] dev_sel;
  logic [15:0] dev_wdata, dev_rdata, mem_wdata, mem_rdata;
  logic [31:0] mem_addr;

  always #2.5 clk = ~clk;

  pingpong_dma u0 (.*);

  localparam logic [4:0] O_CFG = 5'h00, O_SET = 5'h04, O_CLR = 5'h08, O_CTL = 5'h0C,
                         O_AA = 5'h10, O_CA = 5'h14, O_AB = 5'h18, O_CB = 5'h1C;

  logic [47:0] mq[$];
  logic [15:0] dq[$];
  int n_cmp = 0, n_bad = 0, dev_n = 0, exp_n = 0, mem_wr_seen = 0, dev_seen = 0;
  logic err_en = 0;
  logic [31:0] err_addr = 0;
  logic [31:0] v, c1, c2;

  task automatic chk(input bit ok, input string req, input logic [47:0] a, input logic [47:0] e);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  // memory model and scoreboard monitor for memory writes
  initial begin
    logic [47:0] e;
    mem_ack = 0; mem_err = 0; mem_rdata = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 0; mem_err = 0;
      end else if (mem_req && rst_n) begin
        mem_ack = 1;
        if (err_en && mem_addr == err_addr) mem_err = 1;
        else if (mem_we) begin
          mem_wr_seen++;
          if (mq.size() == 0) chk(0, "R6 unexpected memory write", {mem_addr, mem_wdata}, 0);
          else begin
            e = mq.pop_front();
            chk({mem_addr, mem_wdata} == e, "R6 memory write", {mem_addr, mem_wdata}, e);
          end
        end else mem_rdata = mem_addr[15:0] ^ 16'hA5C3;
      end
    end
  end

  // peripheral model and scoreboard monitor for peripheral writes
  initial begin
    logic [15:0] e;
    dev_ack = 0; dev_rdata = 0;
    forever begin
      @(negedge clk);
      if (dev_ack) dev_ack = 0;
      else if (dev_req && rst_n) begin
        dev_ack = 1;
        dev_seen++;
        if (dev_we) begin
          if (dq.size() == 0) chk(0, "R9 unexpected peripheral write", dev_wdata, 0);
          else begin
            e = dq.pop_front();
            chk(dev_wdata == e, "R9 peripheral write", dev_wdata, e);
          end
        end else begin
          dev_rdata = 16'h3C00 + 16'(dev_n);
          dev_n++;
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_ctl(input logic [7:0] mask, input logic [7:0] val, input string req);
    logic [31:0] r;
    for (int i = 0; i < 3000; i++) begin
      rd(O_CTL, r);
      if ((r[7:0] & mask) == val) break;
    end
    chk((r[7:0] & mask) == val, req, r[7:0] & mask, val);
  endtask

  // driver: expected memory writes for peripheral-to-memory beats
  task automatic push_d2m(input logic [31:0] base, input int beats, input bit w16, input bit sw);
    logic [15:0] s, d;
    for (int k = 0; k < beats; k++) begin
      s = 16'h3C00 + 16'(exp_n);
      exp_n++;
      d = !w16 ? {8'h00, s[7:0]} : (sw ? {s[7:0], s[15:8]} : s);
      mq.push_back({base + 32'(k * (w16 ? 2 : 1)), d});
    end
  endtask

  task automatic push_m2d(input logic [31:0] base, input int beats);
    logic [15:0] m;
    for (int k = 0; k < beats; k++) begin
      m = (base[15:0] + 16'(k)) ^ 16'hA5C3;
      dq.push_back({8'h00, m[7:0]});
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(O_CTL, v); chk(v == 0, "R1 control", v, 0);
    rd(O_CFG, v); chk(v == 0, "R1 config", v, 0);
    rd(O_AA, v);  chk(v == 0, "R1 address A", v, 0);
    rd(O_CB, v);  chk(v == 0, "R1 count B", v, 0);
    chk(irq == 0, "R1 irq", irq, 0);

    // R2 / R3 set and clear views
    wr(O_SET, 32'h02); rd(O_CTL, v); chk(v == 32'h02, "R2 set", v, 32'h02);
    wr(O_SET, 32'hAC); rd(O_CTL, v); chk(v == 32'h02, "R3 set ignored on status bits", v, 32'h02);
    wr(O_CLR, 32'h00); rd(O_CTL, v); chk(v == 32'h02, "R2 zero bits no effect", v, 32'h02);
    wr(O_CLR, 32'h02); rd(O_CTL, v); chk(v == 32'h00, "R2 clear", v, 0);

    // R4 alignment, count width, config
    wr(O_AA, 32'h1003); rd(O_AA, v); chk(v == 32'h1000, "R4 alignment", v, 32'h1000);
    wr(O_CA, 32'hFFFF); rd(O_CA, v); chk(v == 32'h1FFF, "R4 count width", v, 32'h1FFF);
    wr(O_CFG, 32'hFFFF_FFA9); rd(O_CFG, v); chk(v == 32'hA9, "R4 config", v, 32'hA9);
    chk(dev_sel == 4'hA, "R4 dev_sel", dev_sel, 4'hA);

    // R6 R7 R5: A then B chained, 16-bit, burst 4
    wr(O_CFG, 32'h09);
    wr(O_AA, 32'h2000); wr(O_CA, 12); wr(O_AB, 32'h3000); wr(O_CB, 6);
    exp_n = dev_n;
    push_d2m(32'h2000, 6, 1, 0); push_d2m(32'h3000, 3, 1, 0);
    dev_dreq = 1;
    wr(O_SET, 32'h53);
    wait_ctl(8'hF8, 8'h28, "R7 both buffers done, active back to A");
    chk(irq == 1, "R5 irq with done", irq, 1);
    rd(O_AA, v); chk(v == 32'h200C, "R6 address A advanced", v, 32'h200C);
    rd(O_CA, v); chk(v == 0, "R6 count A drained", v, 0);
    rd(O_AB, v); chk(v == 32'h3006, "R7 address B advanced", v, 32'h3006);
    chk(mq.size() == 0, "R7 all writes seen", mq.size(), 0);
    wr(O_CLR, 32'h02); chk(irq == 0, "R5 irq masked", irq, 0);
    wr(O_SET, 32'h02); wr(O_CLR, 32'h28); chk(irq == 0, "R5 irq after done clear", irq, 0);
    dev_dreq = 0;
    wr(O_CLR, 32'h03);

    // R8 burst of 8, two requests
    wr(O_CFG, 32'h0D); wr(O_AA, 32'h4000); wr(O_CA, 20);
    exp_n = dev_n; push_d2m(32'h4000, 10, 1, 0);
    wr(O_SET, 32'h11);
    @(negedge clk); dev_dreq = 1; @(negedge clk); dev_dreq = 0;
    repeat (80) @(negedge clk);
    rd(O_CA, v); chk(v == 4, "R8 one burst of 8 beats", v, 4);
    rd(O_AA, v); chk(v == 32'h4010, "R6 position mid transfer", v, 32'h4010);
    chk(mq.size() == 2, "R8 burst stops", mq.size(), 2);
    @(negedge clk); dev_dreq = 1; @(negedge clk); dev_dreq = 0;
    wait_ctl(8'hF8, 8'h88, "R8 short final burst completes A");
    wr(O_CLR, 32'h09);

    // R9 memory to peripheral, 8-bit, on B
    wr(O_CFG, 32'h00); wr(O_AB, 32'h5000); wr(O_CB, 5);
    push_m2d(32'h5000, 5);
    dev_dreq = 1;
    wr(O_SET, 32'h41);
    wait_ctl(8'hF8, 8'h20, "R9 buffer B done");
    chk(dq.size() == 0, "R9 all peripheral writes seen", dq.size(), 0);
    rd(O_AB, v); chk(v == 32'h5005, "R9 byte steps", v, 32'h5005);
    dev_dreq = 0;
    wr(O_CLR, 32'h21);

    // R10 byte swap at 16-bit
    wr(O_CFG, 32'h0B); wr(O_AA, 32'h6000); wr(O_CA, 8);
    exp_n = dev_n; push_d2m(32'h6000, 4, 1, 1);
    dev_dreq = 1;
    wr(O_SET, 32'h11);
    wait_ctl(8'hF8, 8'h88, "R10 swapped transfer done");
    chk(mq.size() == 0, "R10 all writes seen", mq.size(), 0);
    dev_dreq = 0;
    wr(O_CLR, 32'h09);

    // R11 pause and resume on B
    wr(O_CFG, 32'h01); wr(O_AB, 32'h7000); wr(O_CB, 40);
    exp_n = dev_n; push_d2m(32'h7000, 40, 0, 0);
    dev_dreq = 1;
    wr(O_SET, 32'h41);
    repeat (20) @(negedge clk);
    wr(O_CLR, 32'h01);
    repeat (10) @(negedge clk);
    rd(O_CB, c1);
    repeat (30) @(negedge clk);
    rd(O_CB, c2);
    chk(c1 == c2, "R11 count frozen while stopped", c2, c1);
    chk(c1 > 0 && c1 < 40, "R11 stopped mid buffer", c1, 20);
    chk(mq.size() == int'(c1), "R11 stop at beat boundary", mq.size(), c1);
    wr(O_SET, 32'h01);
    wait_ctl(8'hF8, 8'h20, "R11 resumed to completion");
    chk(mq.size() == 0, "R11 all writes seen", mq.size(), 0);
    dev_dreq = 0;
    wr(O_CLR, 32'h21);

    // R12 error response
    wr(O_CFG, 32'h09); wr(O_AA, 32'h8000); wr(O_CA, 16);
    err_en = 1; err_addr = 32'h8004;
    exp_n = dev_n; push_d2m(32'h8000, 2, 1, 0);
    dev_dreq = 1;
    wr(O_SET, 32'h13);
    wait_ctl(8'h05, 8'h04, "R12 error set and run cleared");
    rd(O_AA, v); chk(v == 32'h8004, "R12 address held", v, 32'h8004);
    rd(O_CA, v); chk(v == 12, "R12 count held", v, 12);
    chk(irq == 1, "R12 irq on error", irq, 1);
    chk(mq.size() == 0, "R12 writes before fault", mq.size(), 0);
    err_en = 0; dev_dreq = 0;
    wr(O_CLR, 32'h16);
    rd(O_CTL, v); chk(v == 0, "R12 clean after clear", v, 0);

    // R13 run without start bits
    wr(O_AA, 32'h9000); wr(O_CA, 4);
    c1 = 32'(mem_wr_seen); c2 = 32'(dev_seen);
    dev_dreq = 1;
    wr(O_SET, 32'h01);
    repeat (40) @(negedge clk);
    chk(mem_wr_seen == int'(c1) && dev_seen == int'(c2), "R13 no requests", dev_seen, c2);
    rd(O_CA, v); chk(v == 4, "R13 count untouched", v, 4);
    dev_dreq = 0;
    wr(O_CLR, 32'h01);

    finish_up();
  end
endmodule